// File: doc/BRIEF.md
# Four-Lane Bit Scan and Count Unit

This unit performs one of five single-operand bit manipulations on four independent data lanes in the same cycle. The five operations are bit-order reversal, a count of set bits, a search for the lowest set bit, a search for the highest set bit of an unsigned value, and a search for the highest bit of a signed value that differs from its sign. A strobe launches an operation. A per-lane enable mask selects which lane results are updated. All results appear in output registers one clock later, together with a single-cycle valid flag.

The unit sits in the integer datapath of a vector shader core. The issue logic delivers the opcode and operands already decoded and routed. The unit holds no state apart from its result registers and the valid flag.

Top module: `bitscan_quad`

## Requirements
- R1: Opcode 3'd0 (reverse) writes a result in which source bit i appears at bit DW-1-i, for every bit of the lane.
- R2: Opcode 3'd1 (count) writes the number of 1 bits in the source, zero-extended, in the range 0 to DW.
- R3: Opcode 3'd2 (lowest set) writes the index of the lowest 1 bit. A zero source writes all ones (-1).
- R4: Opcode 3'd3 (unsigned highest) writes the index of the highest 1 bit. A zero source writes all ones.
- R5: Opcode 3'd4 (signed highest) first inverts a source whose top bit is set, then writes the index of the highest 1 bit. Sources 0 and all-ones both write all ones.
- R6: Opcodes 3'd5 to 3'd7 change no lane result and do not raise the valid flag.
- R7: A strobe carrying a legal opcode raises the valid flag in the following cycle only. With no strobe, the flag stays low.
- R8: A lane whose mask bit is clear, or any lane when no strobe is given, keeps its previous result.
- R9: While reset is high, every lane result is zero and the valid flag is low.
- R10: Lane l uses bits [DW*l+DW-1 : DW*l] of both the source bus and the result bus, and mask bit l.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe for one operation |
| op | input | 3 | Operation code |
| wr_mask | input | LANES | Per-lane write enable |
| src_flat | input | LANES*DW | Packed lane operands |
| res_flat | output | LANES*DW | Packed registered lane results |
| res_valid | output | 1 | High for one cycle after a legal launch |

## Verification
The hardest behaviour to reach is the signed search on its boundary values. Only the all-ones pattern, the most negative value and values one step from the sign flip show whether the inversion and the empty case work together. Uniform random operands almost never produce these values. The stimulus therefore draws a large share of operands from a biased pool: zero, all ones, a single set bit, the two extreme signed values and small negative numbers. It also pairs every opcode with random masks, so that held and written lanes mix in the same cycle.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [2:0] {
    OP_REV  = 3'd0,
    OP_POP  = 3'd1,
    OP_LSB  = 3'd2,
    OP_UMSB = 3'd3,
    OP_SMSB = 3'd4
  } bsq_op_e;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/bsq_reverse.sv
// Reversal as log2(DW) swap stages; stage s exchanges neighbouring 2**s-bit blocks.
// DW must be a power of two.
module bsq_reverse #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  output logic [DW-1:0] y
);
  localparam int ST = $clog2(DW);

  always_comb begin
    logic [DW-1:0] cur;
    logic [DW-1:0] nxt;
    cur = a;
    for (int s = 0; s < ST; s++) begin
      for (int b = 0; b < DW; b++) begin
        nxt[b] = cur[b ^ (1 << s)];
      end
      cur = nxt;
    end
    y = cur;
  end
endmodule

// File: rtl/bsq_popcount.sv
module bsq_popcount #(
  parameter int DW = 32,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic [DW-1:0] a,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < DW; i++) begin
      cnt = cnt + {{(CW-1){1'b0}}, a[i]};
    end
  end
endmodule

// File: rtl/bsq_scan.sv
// Priority scan: from_top=1 finds the highest 1, otherwise the lowest.
module bsq_scan #(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] a,
  input  logic          from_top,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] lo_idx, hi_idx;

  always_comb begin
    lo_idx = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (a[i]) lo_idx = i[IW-1:0];
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < DW; i++) begin
      if (a[i]) hi_idx = i[IW-1:0];
    end
  end

  assign hit = |a;
  assign idx = from_top ? hi_idx : lo_idx;
endmodule

// File: rtl/bsq_lane.sv
module bsq_lane
  import bsq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] res
);
  localparam int CW = $clog2(DW + 1);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] rev_y;
  logic [CW-1:0] pop_y;
  logic [DW-1:0] scan_in;
  logic          scan_hit;
  logic [IW-1:0] scan_idx;
  logic          from_top;

  assign scan_in  = (op == OP_SMSB && src[DW-1]) ? ~src : src;
  assign from_top = (op != OP_LSB);

  bsq_reverse  #(.DW(DW)) u_rev  (.a(src), .y(rev_y));
  bsq_popcount #(.DW(DW)) u_pop  (.a(src), .cnt(pop_y));
  bsq_scan     #(.DW(DW)) u_scan (.a(scan_in), .from_top(from_top),
                                  .hit(scan_hit), .idx(scan_idx));

  always_comb begin
    case (op)
      OP_REV:  res = rev_y;
      OP_POP:  res = {{(DW-CW){1'b0}}, pop_y};
      OP_LSB, OP_UMSB, OP_SMSB:
               res = scan_hit ? {{(DW-IW){1'b0}}, scan_idx} : '1;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bitscan_quad.sv
module bitscan_quad
  import bsq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [LANES-1:0]    wr_mask,
  input  logic [LANES*DW-1:0] src_flat,
  output logic [LANES*DW-1:0] res_flat,
  output logic                res_valid
);
  logic legal;
  assign legal = op_legal(op);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] comb_res;
    logic [DW-1:0] q;

    bsq_lane #(.DW(DW)) u_lane (
      .op (op),
      .src(src_flat[l*DW +: DW]),
      .res(comb_res)
    );

    always_ff @(posedge clk) begin
      if (rst)                              q <= '0;
      else if (start && legal && wr_mask[l]) q <= comb_res;
    end

    assign res_flat[l*DW +: DW] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= start && legal;
  end
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int LANES = 4,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [2:0]          op,
  input logic [LANES-1:0]    wr_mask,
  input logic [LANES*DW-1:0] src_flat,
  input logic [LANES*DW-1:0] res_flat,
  input logic                res_valid
);
  function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) flip[i] = v[DW-1-i];
  endfunction

  // R7
  a_r7_valid_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && op <= 3'd4) |=> res_valid);
  // R6 and R7
  a_r6_no_valid_bad_op: assert property (@(posedge clk) disable iff (rst)
    !(start && op <= 3'd4) |=> !res_valid);
  // R1
  a_r1_reverse_lane0: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'd0 && wr_mask[0]) |=> res_flat[DW-1:0] == flip($past(src_flat[DW-1:0])));
  // R2
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'd1 && wr_mask[0]) |=> res_flat[DW-1:0] <= DW);
  // R3
  a_r3_lsb_empty: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'd2 && wr_mask[0] && src_flat[DW-1:0] == '0) |=> &res_flat[DW-1:0]);
  // R4
  a_r4_umsb_empty: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'd3 && wr_mask[0] && src_flat[DW-1:0] == '0) |=> &res_flat[DW-1:0]);
  // R5
  a_r5_smsb_allones: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'd4 && wr_mask[0] && &src_flat[DW-1:0]) |=> &res_flat[DW-1:0]);

  for (genvar l = 0; l < LANES; l++) begin : g_hold
    // R8
    a_r8_lane_hold: assert property (@(posedge clk) disable iff (rst)
      !(start && wr_mask[l] && op <= 3'd4) |=> $stable(res_flat[l*DW +: DW]));
  end
endmodule

bind bitscan_quad bsq_chk #(.LANES(LANES), .DW(DW)) u_chk (.*);

// File: tb/sim_bitscan_quad.sv
module sim_bitscan_quad;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst, start;
  logic [2:0] op;
  logic [LANES-1:0] wr_mask;
  logic [LANES*DW-1:0] src_flat, res_flat;
  logic res_valid;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] mdl [LANES];

  always #(CLK_PERIOD/2) clk = ~clk;

  bitscan_quad #(.LANES(LANES), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .wr_mask(wr_mask),
    .src_flat(src_flat), .res_flat(res_flat), .res_valid(res_valid));

  function automatic logic [DW-1:0] ref_op(input logic [2:0] c, input logic [DW-1:0] x);
    logic [DW-1:0] r;
    logic [DW-1:0] v;
    int n;
    r = '1;
    case (c)
      3'd0: for (int i = 0; i < DW; i++) r[DW-1-i] = x[i];
      3'd1: begin n = 0; for (int i = 0; i < DW; i++) if (x[i]) n++; r = n; end
      3'd2: begin
        for (int i = 0; i < DW; i++) if (x[i]) begin r = i; break; end
      end
      3'd3, 3'd4: begin
        v = (c == 3'd4 && x[DW-1]) ? ~x : x;
        for (int i = DW - 1; i >= 0; i--) if (v[i]) begin r = i; break; end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic expect_eq(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int l = 0; l < LANES; l++) expect_eq(tag, res_flat[l*DW +: DW], mdl[l]);
  endtask

  function automatic string op_tag(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run(input logic [2:0] c, input logic [LANES-1:0] m, input logic [LANES*DW-1:0] s);
    logic ok;
    ok = (c <= 3'd4);
    @(negedge clk);
    start = 1'b1; op = c; wr_mask = m; src_flat = s;
    for (int l = 0; l < LANES; l++)
      if (ok && m[l]) mdl[l] = ref_op(c, s[l*DW +: DW]);
    @(posedge clk); #1;
    expect_eq("R7", {31'd0, res_valid}, {31'd0, ok});
    check_all(m == '0 ? "R8" : (ok ? "R10" : op_tag(c)));
    check_all(op_tag(c));
    @(negedge clk);
    start = 1'b0; src_flat = ~s;
    @(posedge clk); #1;
    expect_eq("R7", {31'd0, res_valid}, 32'd0);
    check_all("R8");
  endtask

  function automatic logic [DW-1:0] pick();
    case ($urandom_range(0, 9))
      0: return '0;
      1: return '1;
      2: return 32'h8000_0000;
      3: return 32'h7fff_ffff;
      4: return 32'd1 << $urandom_range(0, DW-1);
      5: return -($urandom_range(1, 5));
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; op = '0; wr_mask = '0; src_flat = '1;
    for (int l = 0; l < LANES; l++) mdl[l] = '0;
    repeat (3) @(posedge clk); #1;
    expect_eq("R9", {31'd0, res_valid}, 32'd0);
    check_all("R9");
    @(negedge clk); rst = 1'b0;

    // directed corner cases
    run(3'd0, 4'hF, {32'h0000_0001, 32'h8000_0000, 32'h1234_5678, 32'hF0F0_0000});
    run(3'd1, 4'hF, {32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 32'h0F0F_0F0F});
    run(3'd2, 4'hF, {32'h0, 32'h8000_0000, 32'h1, 32'h0000_0F00});
    run(3'd3, 4'hF, {32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0001_0000});
    run(3'd4, 4'hF, {32'hFFFF_FFFF, 32'h0, 32'h8000_0000, 32'h7FFF_FFFF});
    run(3'd4, 4'hF, {32'hFFFF_FFFE, 32'h1, 32'hC000_0000, 32'h4000_0000});
    run(3'd5, 4'hF, {4{32'hAAAA_5555}});
    run(3'd6, 4'hF, {4{32'h1}});
    run(3'd7, 4'hF, {4{32'h0}});
    run(3'd1, 4'h0, {4{32'hFFFF_FFFF}});
    run(3'd0, 4'h5, {32'h1, 32'h2, 32'h3, 32'h4});
    run(3'd3, 4'hA, {32'h1, 32'h2, 32'h3, 32'h4});

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [LANES*DW-1:0] s;
      logic [2:0] c;
      for (int l = 0; l < LANES; l++) s[l*DW +: DW] = pick();
      c = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      run(c, 4'($urandom), s);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule